// File: doc/BRIEF.md
# Programmable AND-Array Logic Block With Output Feedback

This block is a small two-level logic array. The AND plane is set by a configuration of fuse bits and the OR plane is fixed. Four input signals and one fed-back literal reach twelve AND gates. Each AND gate can connect the true form, the complemented form, both forms or neither form of every literal. The twelve gates form four output sections of three gates each. Each section ORs only its own three gates.

The output of one designated section (the feedback section, section 3 by default) drives a fifth literal into the AND gates of the other sections. A sum that needs more than three products can therefore be split across two sections. The gates of the feedback section see their own feedback literal as a constant 0, which breaks the loop by structure.

The fuse image is shifted in serially, one bit per clock while the load enable is high. The outputs stay at 0 until a done strobe arms the array.

Top module: `pal_array`

## Requirements
- R1: After reset every fuse is 1 (connection intact), the array is disarmed and `data_o` is 0.
- R2: While `cfg_load_i` is high, each clock shifts `cfg_bit_i` into the top of the fuse chain and moves every other bit down one place. After 120 loads, the first bit sent sits at fuse index 0. While `cfg_load_i` is low the fuses do not change, whatever `cfg_bit_i` does.
- R3: While the array is disarmed, `data_o` is 0. A clock with `cfg_load_i` high disarms the array. A clock with `cfg_done_i` high and `cfg_load_i` low arms it. `cfg_done_i` is ignored while `cfg_load_i` is high.
- R4: Fuse layout: product p (0..11) belongs to section p/3. Literal l uses fuse p*10+2l for its true form and fuse p*10+2l+1 for its complement. The literal order is l=0..3 for `data_i[0]`..`data_i[3]` and l=4 for the feedback literal. A fuse value of 1 means the connection is intact.
- R5: A product is the AND of all literals whose fuses are intact. A product with no intact fuse evaluates to 1.
- R6: Output bit s is the OR of products 3s..3s+2 only. No product is shared between sections.
- R7: A product with both forms of a literal connected is 0. A section whose fuses are all intact outputs 0.
- R8: The output of section 3 drives the feedback literal seen by the AND gates of sections 0 to 2.
- R9: The AND gates of section 3 see the feedback literal as constant 0 (true form 0, complement 1).
- R10: The four-product sum A+B+C+ABC fits as section 0 = A+B+F, with section 3 = C+ABC. The result is `data_o[0]` = A|B|C and `data_o[3]` = C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_load_i | input | 1 | Serial load enable; disarms the array |
| cfg_bit_i | input | 1 | Serial fuse data |
| cfg_done_i | input | 1 | Arms the array when load is low |
| data_i | input | 4 | Input literals A (bit 0) to D (bit 3) |
| data_o | output | 4 | Section outputs |

## Verification
The checker checks the following on every cycle:
- the shift and hold behaviour of the fuse chain;
- arming and disarming;
- the zero output while disarmed;
- the zero output of any section whose fuses are all intact.

Only the bench scenarios show the logic function itself. These scenarios cover the fuse layout, the fixed OR grouping, the feedback path and its constant-0 view inside the feedback section, and the split four-product example. In each case every input vector is swept and compared with an independent model of the fuse map.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned FORMS_PER_LIT = 2;
  typedef enum logic {
    POL_TRUE = 1'b0,
    POL_COMP = 1'b1
  } fuse_pol_e;
endpackage

// File: rtl/pal_fuse_chain.sv
module pal_fuse_chain #(
  parameter int unsigned N_FUSE = 120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              bit_i,
  input  logic              done_i,
  output logic [N_FUSE-1:0] fuse_o,
  output logic              armed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fuse_o  <= '1;
      armed_o <= 1'b0;
    end else if (load_i) begin
      fuse_o  <= {bit_i, fuse_o[N_FUSE-1:1]};
      armed_o <= 1'b0;
    end else if (done_i) begin
      armed_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pal_and_term.sv
module pal_and_term #(
  parameter int unsigned N_LIT = 5,
  localparam int unsigned W = N_LIT * pal_pkg::FORMS_PER_LIT
) (
  input  logic [W-1:0] lits_i,
  input  logic [W-1:0] fuse_i,
  output logic         prod_o
);
  // a blown fuse forces its column to 1
  assign prod_o = &(lits_i | ~fuse_i);
endmodule

// File: rtl/pal_or_section.sv
module pal_or_section #(
  parameter int unsigned N_PT = 3
) (
  input  logic [N_PT-1:0] prod_i,
  output logic            sum_o
);
  assign sum_o = |prod_i;
endmodule

// File: rtl/pal_array.sv
module pal_array #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_SEC  = 4,
  parameter int unsigned N_PT   = 3,
  parameter int unsigned FB_SEC = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_load_i,
  input  logic            cfg_bit_i,
  input  logic            cfg_done_i,
  input  logic [N_IN-1:0] data_i,
  output logic [N_SEC-1:0] data_o
);
  import pal_pkg::*;

  localparam int unsigned N_LIT  = N_IN + 1;
  localparam int unsigned FPT    = N_LIT * FORMS_PER_LIT;
  localparam int unsigned N_PROD = N_SEC * N_PT;
  localparam int unsigned N_FUSE = N_PROD * FPT;
  localparam int unsigned FB_IDX = N_IN;

  logic [N_FUSE-1:0] fuse;
  logic              armed;
  logic [FPT-1:0]    lits_nofb;
  logic [FPT-1:0]    lits_fb;
  logic [N_PT-1:0]   fb_prod;
  logic              fb_lit;
  logic [N_SEC-1:0]  sec_sum;

  pal_fuse_chain #(.N_FUSE(N_FUSE)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cfg_load_i),
    .bit_i  (cfg_bit_i),
    .done_i (cfg_done_i),
    .fuse_o (fuse),
    .armed_o(armed)
  );

  for (genvar l = 0; l < N_IN; l++) begin : g_lit
    assign lits_nofb[FORMS_PER_LIT*l + POL_TRUE] = data_i[l];
    assign lits_nofb[FORMS_PER_LIT*l + POL_COMP] = ~data_i[l];
    assign lits_fb[FORMS_PER_LIT*l + POL_TRUE]   = data_i[l];
    assign lits_fb[FORMS_PER_LIT*l + POL_COMP]   = ~data_i[l];
  end
  // feedback section sees its own literal as constant 0
  assign lits_nofb[FORMS_PER_LIT*FB_IDX + POL_TRUE] = 1'b0;
  assign lits_nofb[FORMS_PER_LIT*FB_IDX + POL_COMP] = 1'b1;
  assign lits_fb[FORMS_PER_LIT*FB_IDX + POL_TRUE]   = fb_lit;
  assign lits_fb[FORMS_PER_LIT*FB_IDX + POL_COMP]   = ~fb_lit;

  assign fb_lit = |fb_prod;

  for (genvar s = 0; s < N_SEC; s++) begin : g_sec
    if (s == FB_SEC) begin : g_fb
      for (genvar j = 0; j < N_PT; j++) begin : g_pt
        pal_and_term #(.N_LIT(N_LIT)) u_and (
          .lits_i(lits_nofb),
          .fuse_i(fuse[(s*N_PT+j)*FPT +: FPT]),
          .prod_o(fb_prod[j])
        );
      end
      pal_or_section #(.N_PT(N_PT)) u_or (
        .prod_i(fb_prod),
        .sum_o (sec_sum[s])
      );
    end else begin : g_norm
      logic [N_PT-1:0] sp;
      for (genvar j = 0; j < N_PT; j++) begin : g_pt
        pal_and_term #(.N_LIT(N_LIT)) u_and (
          .lits_i(lits_fb),
          .fuse_i(fuse[(s*N_PT+j)*FPT +: FPT]),
          .prod_o(sp[j])
        );
      end
      pal_or_section #(.N_PT(N_PT)) u_or (
        .prod_i(sp),
        .sum_o (sec_sum[s])
      );
    end
  end

  assign data_o = armed ? sec_sum : '0;
endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk #(
  parameter int unsigned N_SEC  = 4,
  parameter int unsigned N_PT   = 3,
  parameter int unsigned FPT    = 10,
  parameter int unsigned N_FUSE = 120
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_load_i,
  input logic              cfg_bit_i,
  input logic              cfg_done_i,
  input logic [N_SEC-1:0]  data_o,
  input logic [N_FUSE-1:0] fuse_i,
  input logic              armed_i
);
  assert_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |=> fuse_i == {$past(cfg_bit_i), $past(fuse_i[N_FUSE-1:1])});

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_load_i |=> $stable(fuse_i));

  assert_disarm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |=> !armed_i);

  assert_arm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_done_i && !cfg_load_i) |=> armed_i);

  assert_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |-> data_o == '0);

  for (genvar s = 0; s < N_SEC; s++) begin : g_intact
    assert_intact_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&fuse_i[s*N_PT*FPT +: N_PT*FPT]) |-> !data_o[s]);
  end
endmodule

bind pal_array pal_array_chk #(
  .N_SEC (N_SEC),
  .N_PT  (N_PT),
  .FPT   (FPT),
  .N_FUSE(N_FUSE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_load_i(cfg_load_i),
  .cfg_bit_i (cfg_bit_i),
  .cfg_done_i(cfg_done_i),
  .data_o    (data_o),
  .fuse_i    (fuse),
  .armed_i   (armed)
);

// File: tb/pal_array_test.sv
module pal_array_test;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       cfg_load_i, cfg_bit_i, cfg_done_i;
  logic [3:0] data_i;
  logic [3:0] data_o;
  int         n_chk = 0;
  int         n_err = 0;
  logic [119:0] img;

  always #5 clk_i = ~clk_i;

  pal_array uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_load_i(cfg_load_i),
    .cfg_bit_i (cfg_bit_i),
    .cfg_done_i(cfg_done_i),
    .data_i    (data_i),
    .data_o    (data_o)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  // mode: 0 true only, 1 complement only, 2 none, 3 both
  task automatic set_lit(input int p, input int l, input int mode);
    img[p*10+2*l]   = (mode == 0 || mode == 3);
    img[p*10+2*l+1] = (mode == 1 || mode == 3);
  endtask

  task automatic blank_pt(input int p);
    for (int l = 0; l < 5; l++) set_lit(p, l, 2);
  endtask

  function automatic logic prod_val(input int p, input logic [4:0] lv);
    logic r = 1'b1;
    for (int l = 0; l < 5; l++) begin
      if (img[p*10+2*l] && !lv[l]) r = 1'b0;
      if (img[p*10+2*l+1] && lv[l]) r = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [3:0] model(input logic [3:0] v);
    logic [3:0] o = '0;
    for (int j = 9; j < 12; j++) o[3] = o[3] | prod_val(j, {1'b0, v});
    for (int p = 0; p < 9; p++) o[p/3] = o[p/3] | prod_val(p, {o[3], v});
    return o;
  endfunction

  task automatic load_img();
    data_i = 4'hF;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk_i);
      cfg_load_i = 1'b1;
      cfg_bit_i  = img[i];
      cfg_done_i = (i == 0);  // done during load must be ignored
      if (i == 2) begin
        #1 check("R3 disarmed during load", data_o, 4'h0);
      end
    end
    @(negedge clk_i);
    cfg_load_i = 1'b0;
    cfg_done_i = 1'b1;
    @(negedge clk_i);
    cfg_done_i = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 16; v++) begin
      data_i = v[3:0];
      #1 check(req, data_o, model(v[3:0]));
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    cfg_load_i = 1'b0;
    cfg_bit_i = 1'b0;
    cfg_done_i = 1'b0;
    data_i = 4'hF;
    #12;
    check("R1 reset output", data_o, 4'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1 check("R3 not yet armed", data_o, 4'h0);
    // arm the unprogrammed array: all connections intact
    cfg_done_i = 1'b1;
    @(negedge clk_i);
    cfg_done_i = 1'b0;
    img = '1;
    for (int v = 0; v < 16; v++) begin
      data_i = v[3:0];
      #1 check("R1 R7 intact array", data_o, 4'h0);
    end

    // R9 R8: feedback section with single fb connections
    img = '1;
    blank_pt(9);  set_lit(9, 4, 0);   // sees 0 -> product 0
    blank_pt(10); set_lit(10, 4, 1);  // sees ~0 -> product 1
    blank_pt(0);  set_lit(0, 4, 0);   // section 0 = F
    load_img();
    for (int v = 0; v < 16; v++) begin
      data_i = v[3:0];
      #1 check("R9 R8 feedback constant", data_o, 4'b1001);
    end

    // R10: A+B+C+ABC split over sections 0 and 3
    img = '1;
    blank_pt(0);  set_lit(0, 0, 0);
    blank_pt(1);  set_lit(1, 1, 0);
    blank_pt(2);  set_lit(2, 4, 0);
    blank_pt(9);  set_lit(9, 2, 0);
    blank_pt(10); set_lit(10, 0, 0); set_lit(10, 1, 0); set_lit(10, 2, 0);
    load_img();
    for (int v = 0; v < 16; v++) begin
      data_i = v[3:0];
      #1 check("R10 R8 split sum", data_o,
               {v[2], 2'b00, (v[2:0] != 3'b000)});
    end

    // R2: serial data toggling with load low leaves the fuses alone
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      cfg_bit_i = k[0];
    end
    for (int v = 0; v < 16; v++) begin
      data_i = v[3:0];
      #1 check("R2 hold without load", data_o,
               {v[2], 2'b00, (v[2:0] != 3'b000)});
    end

    // R6: product in section 1 must not leak into section 2
    img = '1;
    blank_pt(3); set_lit(3, 0, 0); set_lit(3, 1, 0);
    blank_pt(4);
    set_lit(4, 0, 3);
    load_img();
    sweep("R6 R5 R7 grouping");

    // R4 R5 R9: random fuse maps, model-checked exhaustively
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 12; p++) begin
        for (int l = 0; l < 5; l++) begin
          int r = $urandom_range(0, 5);
          set_lit(p, l, (r < 2) ? r : ((r == 5) ? 3 : 2));
        end
      end
      load_img();
      sweep("R4 R5 R6 R9 random map");
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule